// File: doc/BRIEF.md
# Parameter RAM Access Unit

This block carries out one parameter-RAM transfer for each decoded microinstruction. A request gives a direction bit, a zeroing control, a destination select, a size field, a stack-control field and a direct word address. The block holds a 32-bit parameter register and a 24-bit indirect register. It can move a RAM word into either register, or store either register into the RAM, at 32, 24 or 8 bits. A zeroing mode moves zeros in place of the data. Stack control addresses the RAM through the indirect register and can pre-decrement or post-increment it by one word.

The RAM is an internal synchronous array with byte enables. A write commits on the edge that takes the request. A read loads its destination one cycle later and raises a one-cycle done pulse at the same time. Only one read may be outstanding. A load port stands for the microengine's other writer of the two registers, such as the ALU writeback. Through this port the registers can be given values before a store.

Top module: `pram_access_unit`

## Requirements
- R1: While reset is asserted and after it is released, `par_q`, `ind_q` and `rd_done` are all zero until an operation or a load changes them.
- R2: A normal read (`op_dir`=0, `op_pass`=1, `op_dst`=0) loads the RAM word's bytes into `par_q` as chosen by `op_size`: 00 all four bytes, 01 the low three bytes, 10 the low byte, 11 treated as 00. The other bytes of `par_q` keep their values. The result appears two rising edges after the request is sampled. A new request must not be issued while a read is outstanding.
- R3: A normal write (`op_dir`=1, `op_pass`=1, `op_dst`=0) stores the bytes of `par_q` chosen by `op_size` (same encoding as R2) into the addressed RAM word, on the edge that samples the request. The other RAM bytes are left unchanged.
- R4: With `op_dst`=1 and no zeroing, a read loads bits 23:0 of the RAM word into `ind_q`, and a write stores `ind_q` zero-extended to 32 bits. In both cases `op_size` is ignored.
- R5: A zeroing read (`op_pass`=0) with `op_dst`=0 clears the bytes of `par_q` chosen by `op_size` and keeps the rest.
- R6: A zeroing read with `op_dst`=1 clears all 24 bits of `ind_q`, whatever `op_size` holds.
- R7: A zeroing write clears the bytes of the RAM word chosen by `op_size`, for either value of `op_dst`.
- R8: `op_stk`=11 cancels zeroing, so the transfer runs as a normal read or write even with `op_pass`=0.
- R9: When `op_stk` is 00 the RAM word address is `op_addr`. Otherwise the address is `ind_q[ADDR_W+1:2]`. With 01 (post-increment) the access uses the current value of `ind_q`, and `ind_q` then moves up one word. With 10 (pre-decrement) `ind_q` moves down one word, and that new value is both the access address and the stored result. With 11 `ind_q` is left unchanged.
- R10: A stack update adds or subtracts one in `ind_q[15:2]`, wrapping within those 14 bits. Bits 23:16 and 1:0 are unchanged.
- R11: `rd_done` is high for exactly one cycle for every read, zeroing reads included. It is high in the cycle whose values carry the result. A write never raises it.
- R12: A load (`ld_en`) writes `ld_data` into `par_q` (`ld_sel`=0) or into `ind_q[23:0]` (`ld_sel`=1) at the next edge. A load takes priority over a stack update on the same edge. A read result landing on the same edge takes priority over a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation request, one cycle |
| op_dir | input | 1 | 0 read RAM into a register, 1 write RAM from a register |
| op_pass | input | 1 | 1 normal transfer, 0 zeroing |
| op_dst | input | 1 | 0 parameter register, 1 indirect register |
| op_size | input | 2 | 00 32 bits, 01 low 24 bits, 10 low 8 bits, 11 as 00 |
| op_stk | input | 2 | 00 direct, 01 post-increment, 10 pre-decrement, 11 indirect without update |
| op_addr | input | ADDR_W | Direct word address |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 1 | 0 load parameter register, 1 load indirect register |
| ld_data | input | 32 | Load value |
| par_q | output | 32 | Parameter register |
| ind_q | output | 24 | Indirect register |
| rd_done | output | 1 | Read completion pulse |

## Verification
A RAM write and any pointer update or load show up on the edge that samples the request, so they are visible at the next falling edge. A read result and `rd_done` come one edge later, which is two rising edges after the request. A reference model in the bench steps on each rising edge and is compared with `par_q`, `ind_q` and `rd_done` at every falling edge. Each stimulus task holds the bench for two idle cycles after a request, so every read has finished before the next directed check reads the registers.

// File: rtl/pram_pkg.sv
package pram_pkg;

  localparam int PAR_W  = 32;
  localparam int IND_W  = 24;
  localparam int NBYTE  = PAR_W / 8;
  localparam int PTR_LO = 2;
  localparam int PTR_HI = 15;

  typedef enum logic [1:0] {
    SZ_W32 = 2'b00,
    SZ_W24 = 2'b01,
    SZ_W8  = 2'b10,
    SZ_RSV = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    STK_DIRECT  = 2'b00,
    STK_POSTINC = 2'b01,
    STK_PREDEC  = 2'b10,
    STK_INDIR   = 2'b11
  } stk_e;

  function automatic logic [NBYTE-1:0] size_to_mask(input logic [1:0] sz);
    logic [NBYTE-1:0] m;
    unique case (sz)
      SZ_W24:  m = NBYTE'(4'b0111);
      SZ_W8:   m = NBYTE'(4'b0001);
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pram_rst_sync.sv
module pram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/pram_stack_ptr.sv
module pram_stack_ptr
  import pram_pkg::*;
(
  input  logic [IND_W-1:0] ptr_i,
  output logic [IND_W-1:0] ptr_inc_o,
  output logic [IND_W-1:0] ptr_dec_o
);

  localparam int FW = PTR_HI - PTR_LO + 1;

  logic [FW-1:0] field;
  logic [FW-1:0] field_up;
  logic [FW-1:0] field_dn;

  always_comb begin
    field    = ptr_i[PTR_HI:PTR_LO];
    field_up = field + FW'(1);
    field_dn = field - FW'(1);
  end

  assign ptr_inc_o = {ptr_i[IND_W-1:PTR_HI+1], field_up, ptr_i[PTR_LO-1:0]};
  assign ptr_dec_o = {ptr_i[IND_W-1:PTR_HI+1], field_dn, ptr_i[PTR_LO-1:0]};

endmodule

// File: rtl/pram_op_decode.sv
module pram_op_decode
  import pram_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              op_valid,
  input  logic              op_dir,
  input  logic              op_pass,
  input  logic              op_dst,
  input  logic [1:0]        op_size,
  input  logic [1:0]        op_stk,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [PAR_W-1:0]  par_cur,
  input  logic [IND_W-1:0]  ind_cur,
  input  logic [IND_W-1:0]  ptr_inc,
  input  logic [IND_W-1:0]  ptr_dec,
  output logic              zero_eff,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [NBYTE-1:0]  size_mask,
  output logic [NBYTE-1:0]  wr_be,
  output logic [PAR_W-1:0]  wr_data,
  output logic              ind_upd,
  output logic [IND_W-1:0]  ind_nxt
);

  logic [IND_W-1:0] acc_ptr;

  always_comb begin
    zero_eff  = !op_pass && (op_stk != STK_INDIR);
    size_mask = size_to_mask(op_size);

    acc_ptr  = (op_stk == STK_PREDEC) ? ptr_dec : ind_cur;
    ram_addr = (op_stk == STK_DIRECT) ? op_addr : acc_ptr[ADDR_W+PTR_LO-1:PTR_LO];

    ind_upd = op_valid && ((op_stk == STK_POSTINC) || (op_stk == STK_PREDEC));
    ind_nxt = (op_stk == STK_POSTINC) ? ptr_inc : ptr_dec;

    wr_be   = '0;
    wr_data = '0;
    if (op_valid && op_dir) begin
      if (zero_eff) begin
        wr_be   = size_mask;
        wr_data = '0;
      end else if (op_dst) begin
        wr_be   = '1;
        wr_data = {{(PAR_W-IND_W){1'b0}}, ind_cur};
      end else begin
        wr_be   = size_mask;
        wr_data = par_cur;
      end
    end
  end

endmodule

// File: rtl/pram_sram.sv
module pram_sram
  import pram_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTE-1:0]  wr_be,
  input  logic [PAR_W-1:0]  wr_data,
  output logic [PAR_W-1:0]  rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_be[b]) begin
        lane_mem[addr] <= wr_data[8*b +: 8];
      end
      if (rd_en) begin
        lane_q <= lane_mem[addr];
      end
    end

    assign rd_data[8*b +: 8] = lane_q;
  end

endmodule

// File: rtl/pram_access_unit.sv
module pram_access_unit
  import pram_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_dir,
  input  logic              op_pass,
  input  logic              op_dst,
  input  logic [1:0]        op_size,
  input  logic [1:0]        op_stk,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              ld_en,
  input  logic              ld_sel,
  input  logic [31:0]       ld_data,
  output logic [31:0]       par_q,
  output logic [23:0]       ind_q,
  output logic              rd_done
);

  logic rst_s_n;

  logic [PAR_W-1:0] par_r, par_d;
  logic [IND_W-1:0] ind_r, ind_d;
  logic             pend_r, pend_d;
  logic             pend_dst_r, pend_zero_r;
  logic [NBYTE-1:0] pend_mask_r;
  logic             done_r;
  logic             rd_start;

  logic [IND_W-1:0]  ptr_inc, ptr_dec, ind_nxt;
  logic              zero_eff, ind_upd;
  logic [ADDR_W-1:0] ram_addr;
  logic [NBYTE-1:0]  size_mask, wr_be;
  logic [PAR_W-1:0]  wr_data, ram_q;

  pram_rst_sync i_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_s_n)
  );

  pram_stack_ptr i_ptr (
    .ptr_i    (ind_r),
    .ptr_inc_o(ptr_inc),
    .ptr_dec_o(ptr_dec)
  );

  pram_op_decode #(.ADDR_W(ADDR_W)) i_dec (
    .op_valid (op_valid),
    .op_dir   (op_dir),
    .op_pass  (op_pass),
    .op_dst   (op_dst),
    .op_size  (op_size),
    .op_stk   (op_stk),
    .op_addr  (op_addr),
    .par_cur  (par_r),
    .ind_cur  (ind_r),
    .ptr_inc  (ptr_inc),
    .ptr_dec  (ptr_dec),
    .zero_eff (zero_eff),
    .ram_addr (ram_addr),
    .size_mask(size_mask),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .ind_upd  (ind_upd),
    .ind_nxt  (ind_nxt)
  );

  assign rd_start = op_valid && !op_dir;

  pram_sram #(.ADDR_W(ADDR_W)) i_ram (
    .clk    (clk),
    .rd_en  (rd_start),
    .addr   (ram_addr),
    .wr_be  (wr_be),
    .wr_data(wr_data),
    .rd_data(ram_q)
  );

  // Next-state: pointer update, then load, then read return (last wins)
  always_comb begin
    par_d  = par_r;
    ind_d  = ind_r;
    pend_d = rd_start;
    if (ind_upd) begin
      ind_d = ind_nxt;
    end
    if (ld_en) begin
      if (ld_sel) ind_d = ld_data[IND_W-1:0];
      else        par_d = ld_data;
    end
    if (pend_r) begin
      if (pend_dst_r) begin
        ind_d = pend_zero_r ? '0 : ram_q[IND_W-1:0];
      end else begin
        for (int b = 0; b < NBYTE; b++) begin
          if (pend_mask_r[b]) begin
            par_d[8*b +: 8] = pend_zero_r ? 8'h00 : ram_q[8*b +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      par_r  <= '0;
      ind_r  <= '0;
      pend_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      par_r  <= par_d;
      ind_r  <= ind_d;
      pend_r <= pend_d;
      done_r <= pend_r;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pend_dst_r  <= 1'b0;
      pend_zero_r <= 1'b0;
      pend_mask_r <= '0;
    end else if (rd_start) begin
      pend_dst_r  <= op_dst;
      pend_zero_r <= zero_eff;
      pend_mask_r <= size_mask;
    end
  end

  assign par_q   = par_r;
  assign ind_q   = ind_r;
  assign rd_done = done_r;

  // R2: one read in flight
  p_one_in_flight_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    pend_r |-> !op_valid);

  // R11: a read completes with done two edges after the request
  p_done_after_read_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_start |=> ##1 rd_done);

  // R11: a write never produces done
  p_no_done_write_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && op_dir) |=> ##1 !rd_done);

  // R10: stack update leaves the frame bits alone
  p_ptr_frame_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_valid && (op_stk inside {STK_POSTINC, STK_PREDEC}) && !ld_en)
    |=> (ind_q[23:16] == $past(ind_q[23:16])) && (ind_q[1:0] == $past(ind_q[1:0])));

  // R6: zeroing read into the indirect register empties it
  p_ind_zeroed_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pend_r && pend_dst_r && pend_zero_r) |=> (ind_q == '0));

endmodule

// File: tb/test_pram_access_unit.sv
`timescale 1ns/1ps
module test_pram_access_unit;

  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid, op_dir, op_pass, op_dst;
  logic [1:0]    op_size, op_stk;
  logic [AW-1:0] op_addr;
  logic          ld_en, ld_sel;
  logic [31:0]   ld_data;
  logic [31:0]   par_q;
  logic [23:0]   ind_q;
  logic          rd_done;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    cmp_on = 1'b0;
  bit    finished = 1'b0;

  always #10 clk = ~clk;

  pram_access_unit #(.ADDR_W(AW)) i_pram_access_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dir(op_dir),
    .op_pass(op_pass), .op_dst(op_dst), .op_size(op_size), .op_stk(op_stk),
    .op_addr(op_addr), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .par_q(par_q), .ind_q(ind_q), .rd_done(rd_done)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_mem [1 << AW];
  logic [31:0] m_par;
  logic [23:0] m_ind;
  bit          m_pend, m_done;
  bit          p_dst, p_zero;
  logic [3:0]  p_mask;
  logic [31:0] p_data;

  function automatic logic [3:0] mask_of(input logic [1:0] s);
    if (s == 2'b01) return 4'b0111;
    if (s == 2'b10) return 4'b0001;
    return 4'b1111;
  endfunction

  function automatic logic [23:0] ptr_step(input logic [23:0] p, input bit up);
    logic [13:0] f;
    f = up ? p[15:2] + 14'd1 : p[15:2] - 14'd1;
    return {p[23:16], f, p[1:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_par = '0; m_ind = '0; m_pend = 0; m_done = 0;
    end else begin
      bit          zero, nxt_pend;
      logic [3:0]  mk;
      logic [23:0] acc;
      logic [AW-1:0] a;
      m_done   = m_pend;
      nxt_pend = 0;
      if (op_valid) begin
        zero = !op_pass && (op_stk != 2'b11);
        mk   = mask_of(op_size);
        acc  = (op_stk == 2'b10) ? ptr_step(m_ind, 0) : m_ind;
        a    = (op_stk == 2'b00) ? op_addr : acc[AW+1:2];
        if (op_dir) begin
          for (int b = 0; b < 4; b++) begin
            if (zero) begin
              if (mk[b]) m_mem[a][8*b +: 8] = 8'h00;
            end else if (op_dst) begin
              m_mem[a] = {8'h00, m_ind};
            end else if (mk[b]) begin
              m_mem[a][8*b +: 8] = m_par[8*b +: 8];
            end
          end
        end else begin
          p_dst = op_dst; p_zero = zero; p_mask = mk; p_data = m_mem[a];
          nxt_pend = 1;
        end
        if (op_stk == 2'b01) m_ind = ptr_step(m_ind, 1);
        if (op_stk == 2'b10) m_ind = acc;
      end
      if (ld_en) begin
        if (ld_sel) m_ind = ld_data[23:0];
        else        m_par = ld_data;
      end
      if (m_pend) begin
        if (p_dst) m_ind = p_zero ? 24'h0 : p_data[23:0];
        else
          for (int b = 0; b < 4; b++)
            if (p_mask[b]) m_par[8*b +: 8] = p_zero ? 8'h00 : p_data[8*b +: 8];
      end
      m_pend = nxt_pend;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check({cur_tag, " par"},  par_q, m_par);
      check({cur_tag, " ind"},  {8'h0, ind_q}, {8'h0, m_ind});
      check({cur_tag, " done"}, {31'h0, rd_done}, {31'h0, m_done});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic op(input string tag, input bit dir, input bit pass, input bit dst,
                    input logic [1:0] sz, input logic [1:0] stk, input logic [AW-1:0] ad,
                    input bit le = 0, input bit ls = 0, input logic [31:0] ld = 0);
    cur_tag = tag;
    @(negedge clk);
    op_valid = 1; op_dir = dir; op_pass = pass; op_dst = dst;
    op_size = sz; op_stk = stk; op_addr = ad;
    ld_en = le; ld_sel = ls; ld_data = ld;
    @(negedge clk);
    op_valid = 0; ld_en = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load(input string tag, input bit sel, input logic [31:0] d);
    cur_tag = tag;
    @(negedge clk);
    ld_en = 1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic rd(input string tag, input bit pass, input bit dst,
                    input logic [1:0] sz, input logic [1:0] stk, input logic [AW-1:0] ad);
    op(tag, 0, pass, dst, sz, stk, ad);
  endtask

  task automatic wr(input string tag, input bit pass, input bit dst,
                    input logic [1:0] sz, input logic [1:0] stk, input logic [AW-1:0] ad);
    op(tag, 1, pass, dst, sz, stk, ad);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    rst_n = 0; op_valid = 0; op_dir = 0; op_pass = 1; op_dst = 0;
    op_size = 0; op_stk = 0; op_addr = 0; ld_en = 0; ld_sel = 0; ld_data = 0;
    repeat (3) @(negedge clk);
    check("R1 reset par", par_q, 32'h0);
    check("R1 reset ind", {8'h0, ind_q}, 32'h0);
    check("R1 reset done", {31'h0, rd_done}, 32'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 after release par", par_q, 32'h0);
    cmp_on = 1;

    // R7: clear the whole RAM with zeroing writes
    for (int i = 0; i < (1 << AW); i++) wr("R7 clear", 0, 0, 2'b00, 2'b00, AW'(i));

    // R2, R3: full and sized transfers
    load("R12 load par", 0, 32'hA1B2C3D4);
    wr("R3 write 32", 1, 0, 2'b00, 2'b00, 7'd5);
    load("R12 load par", 0, 32'h0);
    rd("R2 read 32", 1, 0, 2'b00, 2'b00, 7'd5);
    check("R2 read 32", par_q, 32'hA1B2C3D4);
    load("R12 load par", 0, 32'h11223344);
    wr("R3 write 24", 1, 0, 2'b01, 2'b00, 7'd6);
    wr("R3 write 8", 1, 0, 2'b10, 2'b00, 7'd7);
    load("R12 load par", 0, 32'hFFFFFFFF);
    rd("R2 read 8", 1, 0, 2'b10, 2'b00, 7'd6);
    check("R2 read 8 merge", par_q, 32'hFFFFFF44);
    rd("R2 read 24", 1, 0, 2'b01, 2'b00, 7'd6);
    check("R3 24-bit write kept top byte", par_q, 32'hFF223344);
    rd("R2 read size 11", 1, 0, 2'b11, 2'b00, 7'd6);
    check("R2 size 11 as 32", par_q, 32'h00223344);
    rd("R3 read 8-bit word", 1, 0, 2'b00, 2'b00, 7'd7);
    check("R3 write 8", par_q, 32'h00000044);

    // R4: indirect register as source or destination
    load("R12 load ind", 1, 32'h00ABCDEF);
    wr("R4 write ind", 1, 1, 2'b10, 2'b00, 7'd8);
    load("R12 load ind", 1, 32'h0);
    rd("R4 read ind", 1, 1, 2'b10, 2'b00, 7'd5);
    check("R4 read ind size ignored", {8'h0, ind_q}, 32'h00B2C3D4);
    load("R12 load par", 0, 32'hDEADBEEF);
    rd("R4 zero-extended", 1, 0, 2'b00, 2'b00, 7'd8);
    check("R4 write zero-extended", par_q, 32'h00ABCDEF);

    // R5, R6, R7: zeroing
    load("R12 load par", 0, 32'hCAFEBABE);
    rd("R5 zero par 24", 0, 0, 2'b01, 2'b00, 7'd8);
    check("R5 zero par 24", par_q, 32'hCA000000);
    rd("R6 zero ind", 0, 1, 2'b10, 2'b00, 7'd8);
    check("R6 zero ind all bits", {8'h0, ind_q}, 32'h0);
    wr("R7 zero write dst1 8", 0, 1, 2'b10, 2'b00, 7'd5);
    rd("R7 readback", 1, 0, 2'b00, 2'b00, 7'd5);
    check("R7 zero write low byte", par_q, 32'hA1B2C300);

    // R8: stack code 11 cancels zeroing
    load("R12 load ind", 1, 32'h007F0016);
    load("R12 load par", 0, 32'h0);
    rd("R8 stk11 read", 0, 0, 2'b00, 2'b11, 7'd0);
    check("R8 regular read", par_q, 32'hA1B2C300);
    check("R9 stk11 no update", {8'h0, ind_q}, 32'h007F0016);

    // R9, R10: post-increment and pre-decrement
    load("R12 load par", 0, 32'h0);
    rd("R9 postinc read", 1, 0, 2'b00, 2'b01, 7'd0);
    check("R9 postinc uses old addr", par_q, 32'hA1B2C300);
    check("R10 postinc ind", {8'h0, ind_q}, 32'h007F001A);
    load("R12 load par", 0, 32'h55667788);
    wr("R9 predec write", 1, 0, 2'b00, 2'b10, 7'd0);
    check("R10 predec ind", {8'h0, ind_q}, 32'h007F0016);
    load("R12 load par", 0, 32'h0);
    rd("R9 predec target", 1, 0, 2'b00, 2'b00, 7'd5);
    check("R9 predec used new addr", par_q, 32'h55667788);

    load("R12 load ind", 1, 32'h0012FFFF);
    rd("R10 wrap up", 1, 0, 2'b00, 2'b01, 7'd0);
    check("R10 wrap up", {8'h0, ind_q}, 32'h00120003);
    rd("R10 wrap down", 1, 0, 2'b00, 2'b10, 7'd0);
    check("R10 wrap down", {8'h0, ind_q}, 32'h0012FFFF);

    // R12: load beats pointer update
    op("R12 load vs ptr", 0, 1, 0, 2'b00, 2'b01, 7'd0, 1, 1, 32'h00000040);
    check("R12 load wins", {8'h0, ind_q}, 32'h00000040);

    // R8 write side: stk 11 zeroing write stores data
    load("R12 load par", 0, 32'h99AABBCC);
    wr("R8 stk11 write", 0, 0, 2'b10, 2'b11, 7'd0);
    load("R12 load par", 0, 32'h0);
    rd("R8 readback", 1, 0, 2'b00, 2'b00, 7'd16);
    check("R8 write not zeroed", par_q, 32'h000000CC);

    // R11: done pulse timing on a read
    cur_tag = "R11";
    @(negedge clk);
    op_valid = 1; op_dir = 0; op_pass = 1; op_dst = 0; op_size = 0; op_stk = 0; op_addr = 7'd5;
    @(negedge clk);
    op_valid = 0;
    check("R11 no done yet", {31'h0, rd_done}, 32'h0);
    @(negedge clk);
    check("R11 done pulse", {31'h0, rd_done}, 32'h1);
    @(negedge clk);
    check("R11 done single", {31'h0, rd_done}, 32'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule